// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vector

This block raises an interrupt request at a fixed, programmable rate and answers the matching acknowledge cycle with a vector number that software has programmed. A free-running base divider turns the reference clock into ticks of four clocks. An optional divide-by-512 stage slows these ticks further. An 8-bit modulus counter then counts them down and reloads on each expiry. The request level and the vector live in a control register. The prescale choice and the modulus live in a timing register. Both registers are written and read through one 16-bit register port.

The request is presented to an interrupt controller as a 3-bit level and is held until an acknowledge arrives at that same level. During that acknowledge the block drives its vector in the same cycle. A freeze input, gated by a freeze-enable input, stops all counting so that a debugger can halt the system without a tick being lost. A level of zero or a modulus of zero keeps the block quiet.

Top module: `periodic_vector_timer`

## Requirements
- R1: After reset, a read of the control register (reg_sel = 0) returns 0x000F (vector 0x0F, level 0), a read of the timing register (reg_sel = 1) returns 0x0000, irq_level is 0 and vec_valid is 0.
- R2: In the control register, the request level sits in bits 10:8 and the vector in bits 7:0. In the timing register, the prescale enable sits in bit 8 and the modulus in bits 7:0. All other bits read as zero whatever was written to them.
- R3: Without prescale, a timing-register write with modulus M ≠ 0 restarts the count, and the request is raised 4·M clocks after the write edge and every 4·M clocks after that (reload on expiry).
- R4: With prescale enabled, the period is M·512·4 clocks, counted from the timing-register write.
- R5: While the request level is 0, no request is raised and irq_level stays 0.
- R6: A modulus of 0 stops the timer, so no request is raised.
- R7: While freeze_en and freeze are both high, counting stops and every frozen clock lengthens the current period by one clock. With freeze_en low, freeze has no effect.
- R8: A raised request drives irq_level to the programmed level and stays until it is acknowledged. An acknowledge at a different level neither clears it nor returns a vector.
- R9: An acknowledge (iack high) whose iack_level equals the pending level sets vec_valid and drives vec_out to the programmed vector in that same cycle. The request is gone after the next clock edge.
- R10: When a matching acknowledge falls in the same cycle as an expiry, the vector is still returned, and the request stays asserted for the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 timing |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| freeze_en | input | 1 | Lets freeze stop the counters |
| freeze | input | 1 | Debug freeze request |
| iack | input | 1 | Interrupt acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Requested level, 0 when idle |
| vec_valid | output | 1 | Vector is being returned this cycle |
| vec_out | output | 8 | Returned vector, 0 when vec_valid is low |

## Verification
The one real overlap is an expiry of the modulus counter in the same clock as a matching acknowledge: one wants to clear the request, the other to set it. The bench programs a modulus of one (a four-clock period), lets the first request stand, and raises the acknowledge so that its active edge is exactly the second expiry edge. It then judges that the vector appears in that cycle and that the request is still up after the edge. A second acknowledge is then needed to clear it. A scoreboard of expected request-rise cycles also catches any surplus or missing request around that collision.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int MOD_W  = 8;
    localparam int BUS_W  = 16;
    localparam int CTRL_W = LVL_W + VEC_W;
    localparam int TIME_W = 1 + MOD_W;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } pit_ctrl_t;

    typedef struct packed {
        logic             prescale;
        logic [MOD_W-1:0] modulus;
    } pit_time_t;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_TIME = 1'b1
    } pit_sel_e;

    function automatic logic [BUS_W-1:0] ctrl_to_bus(input pit_ctrl_t c);
        logic [BUS_W-1:0] r;
        r = '0;
        r[CTRL_W-1:0] = c;
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] time_to_bus(input pit_time_t t);
        logic [BUS_W-1:0] r;
        r = '0;
        r[TIME_W-1:0] = t;
        return r;
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output pit_ctrl_t        ctrl,
    output pit_time_t        timing,
    output logic             restart,
    output logic [MOD_W-1:0] load_mod
);

    pit_ctrl_t ctrl_q;
    pit_time_t time_q;
    pit_ctrl_t wr_ctrl;
    pit_time_t wr_time;
    logic      unused_hi;

    assign wr_ctrl   = pit_ctrl_t'(wdata[CTRL_W-1:0]);
    assign wr_time   = pit_time_t'(wdata[TIME_W-1:0]);
    assign unused_hi = &{1'b0, wdata[BUS_W-1:CTRL_W]};

    assign restart  = wr_en && (pit_sel_e'(sel) == SEL_TIME);
    assign load_mod = wr_time.modulus;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{level: '0, vector: RST_VEC};
            time_q <= '0;
        end else if (wr_en) begin
            if (pit_sel_e'(sel) == SEL_CTRL) ctrl_q <= wr_ctrl;
            else                             time_q <= wr_time;
        end
    end

    always_comb begin
        if (pit_sel_e'(sel) == SEL_CTRL) rdata = ctrl_to_bus(ctrl_q);
        else                             rdata = time_to_bus(time_q);
    end

    assign ctrl   = ctrl_q;
    assign timing = time_q;

    // R2: a control write lands in the fields it addresses
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel) |=> (ctrl_q.level == $past(wdata[CTRL_W-1:VEC_W])
                             && ctrl_q.vector == $past(wdata[VEC_W-1:0])));

endmodule

// File: rtl/pit_divider.sv
module pit_divider
    import pit_pkg::*;
#(
    parameter int BASE_DIV = 4,
    parameter int PRE_DIV  = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [MOD_W-1:0] load_mod,
    input  logic             prescale,
    input  logic [MOD_W-1:0] modulus,
    output logic             expire
);

    localparam int BASE_CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int PRE_CW  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [BASE_CW-1:0] BASE_LAST = BASE_CW'(BASE_DIV - 1);
    localparam logic [PRE_CW-1:0]  PRE_LAST  = PRE_CW'(PRE_DIV - 1);

    logic [BASE_CW-1:0] base_q;
    logic [PRE_CW-1:0]  pre_q;
    logic [MOD_W-1:0]   cnt_q;
    logic               base_tick;
    logic               stage_tick;

    assign base_tick  = run && (base_q == BASE_LAST);
    assign stage_tick = base_tick && (!prescale || (pre_q == PRE_LAST));
    assign expire     = stage_tick && !restart && (cnt_q == MOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            pre_q  <= '0;
            cnt_q  <= '0;
        end else if (restart) begin
            base_q <= '0;
            pre_q  <= '0;
            cnt_q  <= load_mod;
        end else if (run) begin
            base_q <= base_tick ? '0 : base_q + 1'b1;
            if (base_tick) begin
                if (!prescale)            pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                      pre_q <= pre_q + 1'b1;
            end
            if (stage_tick) begin
                if (cnt_q <= MOD_W'(1)) cnt_q <= modulus;
                else                    cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7: a frozen timer keeps every count where it was
    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> ($stable(cnt_q) && $stable(base_q) && $stable(pre_q)));

endmodule

// File: rtl/pit_request.sv
module pit_request
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             expire,
    input  pit_ctrl_t        ctrl,
    input  logic             iack,
    input  logic [LVL_W-1:0] iack_level,
    output logic [LVL_W-1:0] irq_level,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    logic pend_q;
    logic lvl_on;
    logic hit;

    assign lvl_on = (ctrl.level != '0);
    assign hit    = iack && pend_q && lvl_on && (iack_level == ctrl.level);

    always_ff @(posedge clk) begin
        if (rst)                  pend_q <= 1'b0;
        else if (!lvl_on)         pend_q <= 1'b0;
        else if (expire)          pend_q <= 1'b1;
        else if (hit)             pend_q <= 1'b0;
    end

    assign irq_level = (pend_q && lvl_on) ? ctrl.level : '0;
    assign vec_valid = hit;
    assign vec_out   = hit ? ctrl.vector : '0;

    // R8: an unacknowledged request is held
    assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0 && !iack && lvl_on) |=> (irq_level != '0 || !lvl_on));

    // R9: the vector is only returned on an acknowledge at the pending level
    assert_vec_match_R9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (iack && iack_level == irq_level && vec_out == ctrl.vector));

    // R9: a served request drops after the edge
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !expire) |=> (irq_level == '0));

    // R10: an expiry coinciding with the acknowledge keeps the request up
    assert_collide_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && expire) |=> (irq_level != '0 || !lvl_on));

endmodule

// File: rtl/periodic_vector_timer.sv
module periodic_vector_timer
    import pit_pkg::*;
#(
    parameter int                BASE_DIV = 4,
    parameter int                PRE_DIV  = 512,
    parameter logic [VEC_W-1:0]  RST_VEC  = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             freeze_en,
    input  logic             freeze,
    input  logic             iack,
    input  logic [LVL_W-1:0] iack_level,
    output logic [LVL_W-1:0] irq_level,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    pit_ctrl_t        ctrl;
    pit_time_t        timing;
    logic             restart;
    logic [MOD_W-1:0] load_mod;
    logic             run;
    logic             expire;

    assign run = !(freeze_en && freeze);

    pit_regs #(.RST_VEC(RST_VEC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl),
        .timing   (timing),
        .restart  (restart),
        .load_mod (load_mod)
    );

    pit_divider #(.BASE_DIV(BASE_DIV), .PRE_DIV(PRE_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .restart  (restart),
        .load_mod (load_mod),
        .prescale (timing.prescale),
        .modulus  (timing.modulus),
        .expire   (expire)
    );

    pit_request u_req (
        .clk        (clk),
        .rst        (rst),
        .expire     (expire),
        .ctrl       (ctrl),
        .iack       (iack),
        .iack_level (iack_level),
        .irq_level  (irq_level),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out)
    );

    // R6: a zero modulus never lets an expiry through
    assert_zero_mod_R6: assert property (@(posedge clk) disable iff (rst)
        (timing.modulus == '0 && !restart) |-> !expire);

endmodule

// File: tb/test_periodic_vector_timer.sv
module test_periodic_vector_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        freeze_en = 1'b0;
    logic        freeze = 1'b0;
    logic        ack_man = 1'b0;
    logic        ack_auto = 1'b0;
    logic        auto_on = 1'b0;
    logic [2:0]  ack_lvl = '0;
    logic [2:0]  irq_level;
    logic        vec_valid;
    logic [7:0]  vec_out;
    logic [2:0]  prev_irq = '0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          exp_q[$];
    string       mon_tag = "R3";

    periodic_vector_timer i_periodic_vector_timer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .freeze_en(freeze_en), .freeze(freeze),
        .iack(ack_man | ack_auto), .iack_level(ack_lvl),
        .irq_level(irq_level), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: every rising request is popped against the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_irq <= '0;
            ack_auto <= 1'b0;
        end else begin
            if (irq_level != 0 && prev_irq == 0) begin
                if (exp_q.size() == 0) chk({mon_tag, " unexpected request cycle"}, cyc, -1);
                else                   chk({mon_tag, " request cycle"}, cyc, exp_q.pop_front());
            end
            prev_irq <= irq_level;
            ack_auto <= auto_on && (irq_level != 0);
        end
    end

    task automatic do_reset();
        chk("scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
        auto_on = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [15:0] data, output int c0);
        reg_sel = sel;
        reg_wdata = data;
        reg_wr = 1'b1;
        c0 = cyc + 1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        summary();
    end

    initial begin
        int c0;
        int c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_sel = 1'b0; #1;
        chk("R1 control reset", reg_rdata, 16'h000F);
        reg_sel = 1'b1; #1;
        chk("R1 timing reset", reg_rdata, 16'h0000);
        chk("R1 irq idle", irq_level, 0);
        chk("R1 no vector", vec_valid, 0);

        // R2 field layout and reserved bits
        wr(1'b0, 16'hFFFF, c0);
        reg_sel = 1'b0; #1;
        chk("R2 control readback", reg_rdata, 16'h07FF);
        wr(1'b1, 16'hFFFF, c0);
        reg_sel = 1'b1; #1;
        chk("R2 timing readback", reg_rdata, 16'h01FF);
        do_reset();

        // R3 unprescaled periods, two moduli, auto-acknowledged
        mon_tag = "R3";
        ack_lvl = 3'd4;
        auto_on = 1'b1;
        wr(1'b0, 16'h0490, c0);
        wr(1'b1, 16'h0005, c0);
        exp_q.push_back(c0 + 20); exp_q.push_back(c0 + 40); exp_q.push_back(c0 + 60);
        wait_until(c0 + 62);
        wr(1'b1, 16'h0001, c1);
        exp_q.push_back(c1 + 4); exp_q.push_back(c1 + 8);
        wait_until(c1 + 9);
        do_reset();

        // R4 prescaled period
        mon_tag = "R4";
        ack_lvl = 3'd7;
        auto_on = 1'b1;
        wr(1'b0, 16'h0701, c0);
        wr(1'b1, 16'h0102, c0);
        exp_q.push_back(c0 + 4096); exp_q.push_back(c0 + 8192);
        wait_until(c0 + 8194);
        do_reset();

        // R5 level zero stays silent
        mon_tag = "R5";
        wr(1'b0, 16'h0055, c0);
        wr(1'b1, 16'h0001, c0);
        wait_until(c0 + 40);
        chk("R5 level zero irq", irq_level, 0);
        // R6 modulus zero stays silent
        mon_tag = "R6";
        wr(1'b0, 16'h0355, c0);
        wr(1'b1, 16'h0000, c0);
        wait_until(c0 + 40);
        chk("R6 modulus zero irq", irq_level, 0);
        do_reset();

        // R7 freeze stretches the period only when enabled
        mon_tag = "R7";
        ack_lvl = 3'd6;
        auto_on = 1'b1;
        freeze_en = 1'b1;
        wr(1'b0, 16'h0611, c0);
        wr(1'b1, 16'h0003, c0);
        exp_q.push_back(c0 + 22);
        freeze = 1'b1;
        wait_until(c0 + 10);
        freeze = 1'b0;
        wait_until(c0 + 24);
        freeze_en = 1'b0;
        wr(1'b1, 16'h0003, c1);
        exp_q.push_back(c1 + 12);
        freeze = 1'b1;
        wait_until(c1 + 14);
        freeze = 1'b0;
        do_reset();

        // R8 held request, R9 acknowledge and vector
        mon_tag = "R8";
        wr(1'b0, 16'h053C, c0);
        wr(1'b1, 16'h000A, c0);
        exp_q.push_back(c0 + 40);
        wait_until(c0 + 44);
        chk("R8 request level", irq_level, 5);
        ack_lvl = 3'd3;
        ack_man = 1'b1; #1;
        chk("R8 wrong level gives no vector", vec_valid, 0);
        @(negedge clk);
        ack_man = 1'b0;
        chk("R8 request held after wrong level", irq_level, 5);
        ack_lvl = 3'd5;
        ack_man = 1'b1; #1;
        chk("R9 vector valid", vec_valid, 1);
        chk("R9 vector value", vec_out, 8'h3C);
        @(negedge clk);
        ack_man = 1'b0;
        chk("R9 request cleared", irq_level, 0);
        do_reset();

        // R10 acknowledge colliding with an expiry
        mon_tag = "R10";
        wr(1'b0, 16'h0281, c0);
        wr(1'b1, 16'h0001, c0);
        exp_q.push_back(c0 + 4);
        wait_until(c0 + 7);
        ack_lvl = 3'd2;
        ack_man = 1'b1; #1;
        chk("R10 vector valid at collision", vec_valid, 1);
        chk("R10 vector value at collision", vec_out, 8'h81);
        @(negedge clk);
        ack_man = 1'b0;
        chk("R10 request kept", irq_level, 2);
        ack_man = 1'b1;
        @(negedge clk);
        ack_man = 1'b0;
        chk("R10 second acknowledge clears", irq_level, 0);
        do_reset();

        summary();
    end

endmodule